// File: doc/BRIEF.md
# Word FIFO Control and Interrupt Unit

This block sits on the register side of a serial two-wire bus controller. It holds two word queues. The transmit queue is filled from the register bus and drained by the bit engine. The receive queue is filled by the bit engine and drained from the register bus. Around the two queues it provides several controls: a control byte that starts a flush of either queue and sets a trigger threshold for each, an occupancy byte, and an interrupt status byte. The status byte has write-one-to-clear event bits, two live data-request bits and an enable mask. All of these drive a single interrupt line.

Each flush is run by a small sequencer with two states, `FL_IDLE` and `FL_ARMED`. It moves `FL_IDLE -> FL_ARMED` when a control write carries that queue's flush bit. While in `FL_ARMED` the flush bit reads 1 and the queue pointers are reset at the next clock edge. From there the sequencer goes `FL_ARMED -> FL_IDLE`, or `FL_ARMED -> FL_ARMED` if the same cycle carries another flush write for that queue. Pushes and pops are discarded in the cycle that the flush takes effect. The bit engine and the packet decoder are outside this block.

Top module: `wfifo_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0x00, the control byte reads 0x00, the occupancy byte reads 0x80 (8 free, 0 filled), the status byte reads 0x02 (only the transmit data request is set), and `irq` is low.
- R2: A control write (`reg_sel`=0) with bit 1 (transmit) or bit 0 (receive) set makes that bit read 1 for one cycle. At the next edge that queue is emptied and the bit reads 0.
- R3: Control bits 7:5 hold the transmit trigger level and bits 4:2 hold the receive trigger level. Both read back as written.
- R4: Occupancy byte bits 7:4 give the free transmit slots and bits 3:0 give the filled receive words, with a depth of 8 words.
- R5: Each queue returns words in push order. Its read data shows the head word at all times and shows zero when the queue is empty.
- R6: Status bit 1 (transmit data request) is 1 exactly while free transmit slots exceed the transmit trigger level. A write of 1 to this bit has no effect.
- R7: Status bit 0 (receive data request) is 1 exactly while filled receive words exceed the receive trigger level. A write of 1 to this bit has no effect.
- R8: A transmit push while the queue holds 8 words, outside a flush cycle, sets status bit 5 and drops the word.
- R9: A receive pop while the queue is empty, outside a flush cycle, sets status bit 4 and returns zero.
- R10: The event inputs set sticky status bits: packet done sets bit 7, all packets done sets bit 6, no-acknowledge sets bit 3 and arbitration lost sets bit 2. A status write (`reg_sel`=2) clears each bit written as 1. A new event in the same cycle wins over the clear.
- R11: `irq` is 1 exactly when some status bit and its mask bit (`reg_sel`=1 write, where 1 enables the source) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 mask, 2 status clear, 3 none |
| reg_wdata | input | 8 | Register write data |
| tx_push | input | 1 | Register bus pushes a transmit word |
| tx_wdata | input | 32 | Transmit word to push |
| tx_pop | input | 1 | Bit engine takes the transmit head word |
| tx_rdata | output | 32 | Transmit head word |
| rx_push | input | 1 | Bit engine pushes a receive word |
| rx_wdata | input | 32 | Receive word to push |
| rx_pop | input | 1 | Register bus takes the receive head word |
| rx_rdata | output | 32 | Receive head word, zero when empty |
| ev_pkt_done | input | 1 | Packet transfer complete pulse |
| ev_all_done | input | 1 | All packets complete pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ctrl_q | output | 8 | Control byte readback |
| fifo_stat_q | output | 8 | Occupancy byte |
| int_mask_q | output | 8 | Interrupt mask |
| int_stat_q | output | 8 | Interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: a depth of 8 words of 32 bits and 3-bit trigger fields. With only 8 slots, random push and pop traffic fills and drains both queues often, so overflow, underflow and the full and empty boundaries come up regularly. The 3-bit trigger fields let random control writes sweep every threshold from 0 to 7 against every occupancy. Directed sequences add a fill to overflow, a pop from an empty queue, a cycle-by-cycle check of each flush, and a mask sweep.

// File: rtl/wfi_pkg.sv
package wfi_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_ISTAT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FL_IDLE  = 1'b0,
        FL_ARMED = 1'b1
    } flush_state_e;

    localparam int IB_PKT_DONE = 7;
    localparam int IB_ALL_DONE = 6;
    localparam int IB_TX_OVF   = 5;
    localparam int IB_RX_UNF   = 4;
    localparam int IB_NACK     = 3;
    localparam int IB_ARB      = 2;
    localparam int IB_TX_REQ   = 1;
    localparam int IB_RX_REQ   = 0;

    localparam int Q_RX = 0;
    localparam int Q_TX = 1;

endpackage

// File: rtl/wfi_word_fifo.sv
module wfi_word_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic [DW-1:0]                rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;
    assign count   = cnt;
    assign rdata   = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/wfi_flush_seq.sv
module wfi_flush_seq
    import wfi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy
);
    flush_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FL_IDLE:  state_nx = req ? FL_ARMED : FL_IDLE;
            FL_ARMED: state_nx = req ? FL_ARMED : FL_IDLE;
            default:  state_nx = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FL_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            FL_ARMED: busy = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/wfi_irq_bank.sv
module wfi_irq_bank #(
    parameter int NSRC  = 8,
    parameter int NLIVE = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-NLIVE-1:0]   evt_set,
    input  logic [NLIVE-1:0]        live,
    input  logic                    clr_we,
    input  logic [NSRC-NLIVE-1:0]   clr_bits,
    input  logic                    mask_we,
    input  logic [NSRC-1:0]         mask_d,
    output logic [NSRC-1:0]         stat,
    output logic [NSRC-1:0]         mask,
    output logic                    irq
);
    localparam int NSTK = NSRC - NLIVE;

    logic [NSTK-1:0] sticky;
    logic [NSRC-1:0] mask_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky <= '0;
            mask_r <= '0;
        end else begin
            sticky <= (sticky & ~(clr_we ? clr_bits : '0)) | evt_set;
            if (mask_we) mask_r <= mask_d;
        end
    end

    assign stat = {sticky, live};
    assign mask = mask_r;
    assign irq  = |(stat & mask_r);

endmodule

// File: rtl/wfifo_irq_ctrl.sv
module wfifo_irq_ctrl
    import wfi_pkg::*;
#(
    parameter int DW     = 32,
    parameter int DEPTH  = 8,
    parameter int TRIG_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [7:0]    reg_wdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    input  logic          ev_pkt_done,
    input  logic          ev_all_done,
    input  logic          ev_nack,
    input  logic          ev_arb_lost,
    output logic [7:0]    ctrl_q,
    output logic [7:0]    fifo_stat_q,
    output logic [7:0]    int_mask_q,
    output logic [7:0]    int_stat_q,
    output logic          irq
);
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int NQ     = 2;
    localparam int NSRC   = 8;
    localparam int NLIVE  = 2;
    localparam int RX_TLO = 2;
    localparam int TX_TLO = RX_TLO + TRIG_W;

    logic [TRIG_W-1:0] tx_trig, rx_trig;
    logic [NQ-1:0]     fl_req, fl_busy;
    logic              wr_ctrl, wr_mask, wr_istat;
    logic [CW-1:0]     tx_cnt, rx_cnt, tx_free;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_ovf, rx_unf, tx_req, rx_req;
    logic [NSRC-NLIVE-1:0] evt_set;

    assign wr_ctrl  = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign wr_mask  = reg_we && (reg_sel_e'(reg_sel) == SEL_MASK);
    assign wr_istat = reg_we && (reg_sel_e'(reg_sel) == SEL_ISTAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_trig <= '0;
            rx_trig <= '0;
        end else if (wr_ctrl) begin
            tx_trig <= reg_wdata[TX_TLO +: TRIG_W];
            rx_trig <= reg_wdata[RX_TLO +: TRIG_W];
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_flush
        assign fl_req[q] = wr_ctrl && reg_wdata[q];
        wfi_flush_seq u_seq (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (fl_req[q]),
            .busy  (fl_busy[q])
        );
    end

    wfi_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fl_busy[Q_TX]),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    wfi_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fl_busy[Q_RX]),
        .push  (rx_push),
        .wdata (rx_wdata),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign tx_free = CW'(DEPTH) - tx_cnt;
    assign tx_ovf  = tx_push && tx_full && !fl_busy[Q_TX];
    assign rx_unf  = rx_pop && rx_empty && !fl_busy[Q_RX];
    assign tx_req  = tx_free > CW'(tx_trig);
    assign rx_req  = rx_cnt > CW'(rx_trig);

    assign evt_set = {ev_pkt_done, ev_all_done, tx_ovf, rx_unf, ev_nack, ev_arb_lost};

    wfi_irq_bank #(.NSRC(NSRC), .NLIVE(NLIVE)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .live     ({tx_req, rx_req}),
        .clr_we   (wr_istat),
        .clr_bits (reg_wdata[NSRC-1:NLIVE]),
        .mask_we  (wr_mask),
        .mask_d   (reg_wdata),
        .stat     (int_stat_q),
        .mask     (int_mask_q),
        .irq      (irq)
    );

    assign ctrl_q      = {tx_trig, rx_trig, fl_busy[Q_TX], fl_busy[Q_RX]};
    assign fifo_stat_q = {4'(tx_free), 4'(rx_cnt)};

endmodule

// File: rtl/wfi_checker.sv
module wfi_checker #(
    parameter int DEPTH = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [1:0] reg_sel,
    input logic [7:0] reg_wdata,
    input logic       tx_push,
    input logic       rx_pop,
    input logic       ev_nack,
    input logic [7:0] ctrl_q,
    input logic [7:0] fifo_stat_q,
    input logic [7:0] int_mask_q,
    input logic [7:0] int_stat_q,
    input logic       irq
);
    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask_q == 8'h00) |-> !irq);

    assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_stat_q[7:4] <= 4'(DEPTH)) && (fifo_stat_q[3:0] <= 4'(DEPTH)));

    assert_tx_flush_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctrl_q[1]) && !(reg_we && reg_sel == 2'd0 && reg_wdata[1]))
        |=> (fifo_stat_q[7:4] == 4'(DEPTH)) && !ctrl_q[1]);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && fifo_stat_q[7:4] == 4'd0 && !ctrl_q[1]) |=> int_stat_q[5]);

    assert_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && fifo_stat_q[3:0] == 4'd0 && !ctrl_q[0]) |=> int_stat_q[4]);

    assert_nack_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> int_stat_q[3]);

endmodule

bind wfifo_irq_ctrl wfi_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .tx_push     (tx_push),
    .rx_pop      (rx_pop),
    .ev_nack     (ev_nack),
    .ctrl_q      (ctrl_q),
    .fifo_stat_q (fifo_stat_q),
    .int_mask_q  (int_mask_q),
    .int_stat_q  (int_stat_q),
    .irq         (irq)
);

// File: tb/wfifo_irq_ctrl_tb.sv
module wfifo_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd3;
    logic [7:0]  reg_wdata = '0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0;
    logic [31:0] tx_rdata, rx_rdata;
    logic        ev_pkt_done = 1'b0, ev_all_done = 1'b0, ev_nack = 1'b0, ev_arb_lost = 1'b0;
    logic [7:0]  ctrl_q, fifo_stat_q, int_mask_q, int_stat_q;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_txq[$];
    logic [31:0] m_rxq[$];
    logic [1:0]  m_pend = '0;
    logic [7:0]  m_mask = '0;
    logic [7:0]  m_sticky = '0;
    logic [2:0]  m_ttrig = '0, m_rtrig = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wfifo_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .ev_pkt_done(ev_pkt_done), .ev_all_done(ev_all_done), .ev_nack(ev_nack),
        .ev_arb_lost(ev_arb_lost), .ctrl_q(ctrl_q), .fifo_stat_q(fifo_stat_q),
        .int_mask_q(int_mask_q), .int_stat_q(int_stat_q), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_ctrl();
        return {m_ttrig, m_rtrig, m_pend};
    endfunction

    function automatic logic [7:0] exp_occ();
        return {4'(DEPTH - m_txq.size()), 4'(m_rxq.size())};
    endfunction

    function automatic logic [7:0] exp_stat();
        logic txr, rxr;
        txr = (DEPTH - m_txq.size()) > int'(m_ttrig);
        rxr = m_rxq.size() > int'(m_rtrig);
        return {m_sticky[7:2], txr, rxr};
    endfunction

    task automatic idle_inputs();
        reg_we = 0; reg_sel = 2'd3; reg_wdata = '0;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        ev_pkt_done = 0; ev_all_done = 0; ev_nack = 0; ev_arb_lost = 0;
    endtask

    task automatic model_edge();
        int tsz, rsz;
        logic [7:0] set, clr;
        tsz = m_txq.size();
        rsz = m_rxq.size();
        set = '0;
        if (m_pend[1]) m_txq.delete();
        else begin
            if (tx_pop && tsz > 0) void'(m_txq.pop_front());
            if (tx_push) begin
                if (tsz == DEPTH) set[5] = 1'b1;
                else m_txq.push_back(tx_wdata);
            end
        end
        if (m_pend[0]) m_rxq.delete();
        else begin
            if (rx_pop) begin
                if (rsz == 0) set[4] = 1'b1;
                else void'(m_rxq.pop_front());
            end
            if (rx_push && rsz < DEPTH) m_rxq.push_back(rx_wdata);
        end
        set[7] = ev_pkt_done; set[6] = ev_all_done; set[3] = ev_nack; set[2] = ev_arb_lost;
        clr = (reg_we && reg_sel == 2'd2) ? reg_wdata : 8'h00;
        m_sticky = ((m_sticky & ~clr) | set) & 8'hFC;
        if (reg_we && reg_sel == 2'd0) begin
            m_pend  = reg_wdata[1:0];
            m_ttrig = reg_wdata[7:5];
            m_rtrig = reg_wdata[4:2];
        end else m_pend = 2'b00;
        if (reg_we && reg_sel == 2'd1) m_mask = reg_wdata;
    endtask

    task automatic cyc();
        chk(tx_rdata, m_txq.size() > 0 ? m_txq[0] : 32'h0, "R5 tx head");
        chk(rx_rdata, m_rxq.size() > 0 ? m_rxq[0] : 32'h0, "R5/R9 rx head");
        @(posedge clk); #1;
        model_edge();
        chk({24'h0, ctrl_q}, {24'h0, exp_ctrl()}, "R2/R3 ctrl");
        chk({24'h0, fifo_stat_q}, {24'h0, exp_occ()}, "R4 occupancy");
        chk({24'h0, int_stat_q}, {24'h0, exp_stat()}, "R6/R7/R8/R10 status");
        chk({24'h0, int_mask_q}, {24'h0, m_mask}, "R11 mask");
        chk({31'h0, irq}, {31'h0, |(exp_stat() & m_mask)}, "R11 irq");
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        idle_inputs();
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        cyc();
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle_inputs();
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk({24'h0, int_mask_q}, 32'h0, "R1 mask reset");
        chk({24'h0, ctrl_q}, 32'h0, "R1 ctrl reset");
        chk({24'h0, fifo_stat_q}, 32'h80, "R1 occupancy reset");
        chk({24'h0, int_stat_q}, 32'h02, "R1 status reset");
        chk({31'h0, irq}, 32'h0, "R1 irq reset");
        rst_n = 1;
        @(posedge clk); #1;

        // R3: trigger fields read back, R6 threshold at free=8 vs trig 7
        wr(2'd0, 8'b111_101_00);
        chk({24'h0, ctrl_q}, 32'hF4, "R3 trigger readback");
        chk({31'h0, int_stat_q[1]}, 32'h1, "R6 free 8 > trig 7");

        // R8: fill TX to full then overflow
        for (int i = 0; i < DEPTH + 1; i++) begin
            idle_inputs(); tx_push = 1; tx_wdata = 32'hA000_0000 + i; cyc();
        end
        idle_inputs();
        chk({31'h0, int_stat_q[5]}, 32'h1, "R8 overflow flag");
        chk({24'h0, fifo_stat_q}, 32'h00, "R8 dropped word, 0 free");
        chk(tx_rdata, 32'hA000_0000, "R5 first pushed word at head");
        // R6: write 1 to live bit has no effect, clear overflow
        wr(2'd2, 8'h23);
        chk({24'h0, int_stat_q}, 32'h00, "R6/R10 W1C clears sticky, live unaffected");

        // R2: TX flush sequence
        wr(2'd0, 8'b000_000_10);
        chk({31'h0, ctrl_q[1]}, 32'h1, "R2 flush bit reads 1");
        idle_inputs(); tx_push = 1; tx_wdata = 32'hDEAD; cyc();
        idle_inputs();
        chk({31'h0, ctrl_q[1]}, 32'h0, "R2 flush bit self-clears");
        chk({24'h0, fifo_stat_q}, 32'h80, "R2 TX emptied, push discarded");

        // R9: RX underflow returns zero
        idle_inputs(); rx_pop = 1;
        chk(rx_rdata, 32'h0, "R9 empty pop data zero");
        cyc(); idle_inputs();
        chk({31'h0, int_stat_q[4]}, 32'h1, "R9 underflow flag");

        // R7: RX data request vs trig 1
        wr(2'd0, 8'b000_001_00);
        idle_inputs(); rx_push = 1; rx_wdata = 32'h11; cyc();
        chk({31'h0, int_stat_q[0]}, 32'h0, "R7 1 word not > trig 1");
        rx_wdata = 32'h22; cyc(); idle_inputs();
        chk({31'h0, int_stat_q[0]}, 32'h1, "R7 2 words > trig 1");

        // R10/R11: event and mask
        idle_inputs(); ev_nack = 1; cyc(); idle_inputs();
        chk({31'h0, irq}, 32'h0, "R11 unmasked event no irq");
        wr(2'd1, 8'h08);
        chk({31'h0, irq}, 32'h1, "R11 masked-in nack raises irq");
        idle_inputs(); reg_we = 1; reg_sel = 2'd2; reg_wdata = 8'h08; ev_nack = 1; cyc(); idle_inputs();
        chk({31'h0, int_stat_q[3]}, 32'h1, "R10 set wins over clear");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            idle_inputs();
            tx_push = ($urandom % 2) == 0;
            tx_pop  = ($urandom % 3) == 0;
            rx_push = ($urandom % 3) == 0;
            rx_pop  = ($urandom % 5) < 2;
            tx_wdata = $urandom; rx_wdata = $urandom;
            ev_pkt_done = ($urandom % 20) == 0;
            ev_all_done = ($urandom % 20) == 0;
            ev_nack     = ($urandom % 20) == 0;
            ev_arb_lost = ($urandom % 20) == 0;
            if (($urandom % 8) == 0) begin
                reg_we = 1; reg_sel = 2'($urandom % 4); reg_wdata = 8'($urandom);
                if (reg_sel == 2'd0 && ($urandom % 6) != 0) reg_wdata[1:0] = 2'b00;
            end
            cyc();
        end
        idle_inputs();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule